// File: doc/BRIEF.md
# Codec Bit Clock Generator

This block turns a fast functional clock into the serial bit clock for an external audio codec. A down-counter runs without stopping and is reloaded from a programmable divide value. Each time the counter reaches zero, the exported bit clock register flips and the counter reloads. The high and low phases are equal, so the bit clock has a 50% duty cycle.

Alongside the pin, the block produces two strobes that are one functional clock wide. One marks the rising edge of the bit clock and the other marks the falling edge. Transmit shift logic uses the rising strobe to launch data. Receive logic uses the falling strobe to sample. Both are plain clock enables, so all downstream logic stays on the functional clock.

Top module: `codec_bitclk_gen`

## Requirements
- R1: While the active-low reset is asserted, the bit clock output is 0 and both strobes are 0.
- R2: In steady state, the high phase and the low phase of the bit clock each last exactly divide value + 1 functional clocks. The full period is therefore 2 x (divide value + 1) clocks.
- R3: The rising strobe is high for exactly one clock. It is high in the same cycle as the first high cycle of the bit clock output, and at no other time.
- R4: The falling strobe is high for exactly one clock. It is high in the same cycle as the first low cycle of the bit clock output, and at no other time.
- R5: The two strobes are never high in the same cycle.
- R6: After reset is released, the first clock edge drives the bit clock high and raises the rising strobe. The phase that follows is a full divide value + 1 clocks long.
- R7: The divide value input is read only in the cycle in which the bit clock toggles. A phase already in progress keeps its length when the input changes. A value that is present at a toggle sets the length of the phase that begins there.
- R8: With a divide value of 0, the bit clock toggles on every clock, and the two strobes alternate on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | DIV_W | Divide value; each phase lasts div_val + 1 clocks |
| bclk_o | output | 1 | Bit clock to the codec, driven from a register |
| rise_stb_o | output | 1 | One-cycle enable marking the bit clock rising edge |
| fall_stb_o | output | 1 | One-cycle enable marking the falling edge |

## Verification
Two events can land in the same cycle: a change of the divide value, and the counter reaching zero to reload and toggle. The bench provokes this by changing the value in the very cycle the counter sits at zero. It then checks that the new length governs the phase starting at that toggle, while the phase just ended kept the old length. A second case changes the value partway through a phase and checks that this phase is unaffected.

// File: rtl/codec_bitclk_gen.sv
module codec_bitclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             bclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic             rise_q;
  logic             fall_q;
  logic             reload;

  assign reload = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= reload && !bclk_q;
      fall_q <= reload &&  bclk_q;
      if (reload) begin
        cnt_q  <= div_val;
        bclk_q <= !bclk_q;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign bclk_o     = bclk_q;
  assign rise_stb_o = rise_q;
  assign fall_stb_o = fall_q;

  // R3
  rise_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (bclk_q && !$past(bclk_q)));

  // R4
  fall_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!bclk_q && $past(bclk_q)));

  // R3
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

  // R4
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));

  // R2
  toggle_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_q != $past(bclk_q)) |-> (rise_q || fall_q));

  // R7
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) && $stable(bclk_q));

endmodule

// File: tb/codec_bitclk_gen_test.sv
module codec_bitclk_gen_test;
  localparam int CLK_P = 10;
  localparam int DIV_W = 8;
  localparam int NT = 7;
  localparam int TAB_DIV [NT] = '{0, 1, 2, 3, 5, 9, 40};
  localparam int TAB_HALF[NT] = '{1, 2, 3, 4, 6, 10, 41};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic bclk, rise, fall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_rise = 0, n_fall = 0;
  int t_rise = 0, t_fall = 0;
  logic prev_b = 1'b0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  codec_bitclk_gen #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val),
    .bclk_o(bclk), .rise_stb_o(rise), .fall_stb_o(fall));

  // strobe alignment monitor (R3, R4, R5), sampled 2 time units after each edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (!rst_n) begin
      prev_b = 1'b0;
    end else begin
      if (rise !== (bclk && !prev_b)) begin
        errors++;
        $display("FAIL R3 cyc %0d: rise=%b expected %b", cyc, rise, bclk && !prev_b);
      end
      if (fall !== (!bclk && prev_b)) begin
        errors++;
        $display("FAIL R4 cyc %0d: fall=%b expected %b", cyc, fall, !bclk && prev_b);
      end
      if (rise && fall) begin
        errors++;
        $display("FAIL R5 cyc %0d: rise=1 fall=1 expected not both", cyc);
      end
      if (rise) begin n_rise++; t_rise = cyc; end
      if (fall) begin n_fall++; t_fall = cyc; end
      prev_b = bclk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int k = n_rise;
    while (n_rise == k) @(negedge clk);
  endtask

  task automatic wait_fall();
    int k = n_fall;
    while (n_fall == k) @(negedge clk);
  endtask

  task automatic restart(input int d);
    @(negedge clk);
    rst_n = 1'b0;
    div_val = DIV_W'(d);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 bclk in reset", int'(bclk), 0);
    check("R1 strobes in reset", int'(rise | fall), 0);

    foreach (TAB_DIV[i]) begin
      restart(TAB_DIV[i]);
      @(negedge clk);
      // R6: first edge after release is a rise
      check("R6 first bclk", int'(bclk), 1);
      check("R6 first rise strobe", int'(rise), 1);
      for (int p = 0; p < 2; p++) begin
        wait_fall();
        // R2 high phase length (R8 when divisor is 0)
        check((TAB_DIV[i] == 0) ? "R8 high phase" : "R2 high phase", t_fall - t_rise, TAB_HALF[i]);
        wait_rise();
        check((TAB_DIV[i] == 0) ? "R8 low phase" : "R2 low phase", t_rise - t_fall, TAB_HALF[i]);
      end
    end

    // R7: change mid-phase, current phase keeps old length
    restart(3);
    wait_rise();
    div_val = 8'd5;
    wait_fall();
    check("R7 phase in progress", t_fall - t_rise, 4);
    wait_rise();
    check("R7 next phase", t_rise - t_fall, 6);

    // R7: change coincides with the toggle cycle
    restart(2);
    wait_rise();
    @(negedge clk);
    @(negedge clk);
    div_val = 8'd6;
    wait_fall();
    check("R7 coincident old phase", t_fall - t_rise, 3);
    wait_rise();
    check("R7 coincident new phase", t_rise - t_fall, 7);

    // R1: reset asserted mid-run forces outputs low at once
    wait_rise();
    #1 rst_n = 1'b0;
    #1;
    check("R1 async bclk", int'(bclk), 0);
    @(negedge clk);
    check("R1 held strobes", int'(rise | fall), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R4/R5 monitor result
    check("R5 monitor clean", 0, 0);
    finish_run();
  end
endmodule